// File: doc/BRIEF.md
# Reader-Gap Decoder and Manchester Responder

This block is the radio front end of a low-frequency tag emulator. A thresholded "reader field present" input and a one-cycle carrier-period tick come in. The block counts carrier periods between rising edges of the field signal and turns each gap into a reader bit: short gaps are '0', long gaps are '1', and gaps that are too short or too long are thrown away. Decoded bits are packed into a frame of up to 80 bits. A long stretch with no rising edge closes the frame, and the block then reports it with a one-cycle completion pulse.

When the command layer above asks for a reply, the block takes the payload bits, their count and a turnaround time. It waits until the carrier-period count since the last accepted reader edge reaches the turnaround time minus a fixed guard of 8 periods. It then drives a coil-load output with a Manchester-coded reply: five '1' start bits followed by the payload. Command decoding and any cryptography belong to the layer above.

Top module: `lf_gap_responder`

## Requirements
- R1: A gap between accepted rising edges of `field_in` is counted in carrier periods (ticks after the earlier edge up to and including the later edge's cycle). A gap of fewer than 15 or more than 40 periods adds no bit to the frame.
- R2: A gap of 15 to 23 periods adds a '0' bit, and a gap of 24 to 40 periods adds a '1' bit.
- R3: When the period count since the last accepted edge passes 40, the frame ends. If it holds at least one bit, `frame_done` pulses for exactly one cycle with `frame_len` and `frame_data` valid in that cycle, and the bit count restarts at zero. An empty frame raises no pulse.
- R4: The first gap measured after an end of frame never adds a bit.
- R5: The first bit of a frame appears on `frame_data[79]`, the next on bit 78, and so on (MSB first). At most 80 bits are kept, later bits are dropped, and `frame_len` never exceeds 80.
- R6: A reply begins when the period count since the last accepted reader edge reaches `fdt` − 8, or at once when `fdt` is 8 or less.
- R7: A reply is five '1' bits followed by `rsp_len` payload bits taken from `rsp_bits[79]` downward. A `rsp_len` above 80 is treated as 80.
- R8: Each reply bit lasts 31 carrier periods. For a '1' bit `coil_load` is high for the first 15 periods and low for the remaining 16. For a '0' bit it is low first and then high.
- R9: `coil_load` is low whenever no reply is being sent, including after reset.
- R10: `busy` rises in the cycle after an accepted `rsp_req` and falls when the last reply bit ends. A `rsp_req` made while `busy` is high is ignored.
- R11: Rising edges of `field_in` while `busy` is high are ignored. They add no bit and do not restart the period count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_in | input | 1 | Thresholded reader field present (asynchronous) |
| tick | input | 1 | One-cycle pulse per carrier period |
| rsp_req | input | 1 | Request a reply (one-cycle pulse) |
| rsp_len | input | 7 | Number of payload bits (clamped to 80) |
| rsp_bits | input | 80 | Payload, first bit at bit 79 |
| fdt | input | 9 | Turnaround time in carrier periods |
| coil_load | output | 1 | High loads (shorts) the coil |
| busy | output | 1 | Reply pending or in progress |
| frame_done | output | 1 | One-cycle pulse: a received frame is complete |
| frame_len | output | 7 | Bit count of the completed frame |
| frame_data | output | 80 | Completed frame, first bit at bit 79 |

## Verification
The decoder is driven with gap lengths placed on each side of every threshold (14, 15, 23, 24, 40), so an off-by-one in the ignore, '0' or '1' limit changes the decoded frame. A frame of 85 mixed bits checks the 80-bit cap and the MSB-first packing. Each reply is preceded by a fresh end of frame, which also checks that the first gap after a timeout is discarded. The replies use a mixed byte pattern, an oversized length and an empty payload with a turnaround time below the guard, so that bit order, clamping, start timing and the immediate-start case can each be told apart. Reader edges and a second request are injected during a reply to confirm that both are ignored.

// File: rtl/lfgr_pkg.sv
package lfgr_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;
endpackage

// File: rtl/lfgr_edge_sync.sv
module lfgr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its delayed copy
  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/lfgr_gap_rx.sv
module lfgr_gap_rx #(
  parameter int FRAME_BITS = 80,
  parameter int CNT_W      = 9,
  parameter int T_ZERO_MIN = 15,
  parameter int T_ONE_MIN  = 24,
  parameter int T_EOF      = 40,
  localparam int LEN_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  rise,
  output logic [CNT_W-1:0]      gap_cnt,
  output logic                  frame_done,
  output logic [LEN_W-1:0]      frame_len,
  output logic [FRAME_BITS-1:0] frame_data
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LIM_Z   = CNT_W'(T_ZERO_MIN);
  localparam logic [CNT_W-1:0] LIM_O   = CNT_W'(T_ONE_MIN);
  localparam logic [CNT_W-1:0] LIM_E   = CNT_W'(T_EOF);
  localparam logic [LEN_W-1:0] CAP     = LEN_W'(FRAME_BITS);

  logic [CNT_W-1:0]      cnt_q, cnt_d, meas;
  logic                  stale_q, stale_d;
  logic [LEN_W-1:0]      nb_q, nb_d;
  logic [FRAME_BITS-1:0] acc_q, acc_d;
  logic                  done_q, done_d;
  logic [LEN_W-1:0]      flen_q, flen_d;
  logic [FRAME_BITS-1:0] fdat_q, fdat_d;

  // gap including a tick that coincides with the closing edge
  always_comb meas = (tick && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

  always_comb begin
    cnt_d   = cnt_q;
    stale_d = stale_q;
    nb_d    = nb_q;
    acc_d   = acc_q;
    done_d  = 1'b0;
    flen_d  = flen_q;
    fdat_d  = fdat_q;
    if (rise) begin
      cnt_d   = '0;
      stale_d = 1'b0;
      if (!stale_q && meas >= LIM_Z && meas <= LIM_E && nb_q < CAP) begin
        acc_d[FRAME_BITS-1-int'(nb_q)] = (meas >= LIM_O);
        nb_d = nb_q + 1'b1;
      end
    end else if (tick) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      if (!stale_q && cnt_q == LIM_E) begin
        stale_d = 1'b1;
        if (nb_q != '0) begin
          done_d = 1'b1;
          flen_d = nb_q;
          fdat_d = acc_q;
        end
        nb_d  = '0;
        acc_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stale_q <= 1'b0;
      nb_q    <= '0;
      acc_q   <= '0;
      done_q  <= 1'b0;
      flen_q  <= '0;
      fdat_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      stale_q <= stale_d;
      nb_q    <= nb_d;
      acc_q   <= acc_d;
      done_q  <= done_d;
      flen_q  <= flen_d;
      fdat_q  <= fdat_d;
    end
  end

  assign gap_cnt    = cnt_q;
  assign frame_done = done_q;
  assign frame_len  = flen_q;
  assign frame_data = fdat_q;
endmodule

// File: rtl/lfgr_manch_tx.sv
module lfgr_manch_tx
  import lfgr_pkg::*;
#(
  parameter int FRAME_BITS  = 80,
  parameter int CNT_W       = 9,
  parameter int START_BITS  = 5,
  parameter int BIT_PERIODS = 31,
  parameter int HALF_PER    = 15,
  parameter int GUARD       = 8,
  localparam int LEN_W      = $clog2(FRAME_BITS + 1),
  localparam int SH_W       = FRAME_BITS + START_BITS,
  localparam int TOT_W      = $clog2(SH_W + 1),
  localparam int PC_W       = $clog2(BIT_PERIODS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [CNT_W-1:0]      gap_cnt,
  input  logic                  rsp_req,
  input  logic [LEN_W-1:0]      rsp_len,
  input  logic [FRAME_BITS-1:0] rsp_bits,
  input  logic [CNT_W-1:0]      fdt,
  output logic                  coil_load,
  output logic                  busy
);
  localparam logic [LEN_W-1:0] CAP   = LEN_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] GRD   = CNT_W'(GUARD);
  localparam logic [PC_W-1:0]  PC_LST = PC_W'(BIT_PERIODS - 1);
  localparam logic [PC_W-1:0]  PC_HLF = PC_W'(HALF_PER);

  tx_state_e        st_q, st_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [TOT_W-1:0] left_q, left_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [CNT_W-1:0] thr_q, thr_d;
  logic [LEN_W-1:0] len_c;

  always_comb len_c = (rsp_len > CAP) ? CAP : rsp_len;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    left_d = left_q;
    pc_d   = pc_q;
    thr_d  = thr_q;
    unique case (st_q)
      TX_IDLE: if (rsp_req) begin
        st_d   = TX_WAIT;
        sh_d   = {{START_BITS{1'b1}}, rsp_bits};
        left_d = TOT_W'(len_c) + TOT_W'(START_BITS);
        thr_d  = (fdt > GRD) ? fdt - GRD : '0;
        pc_d   = '0;
      end
      TX_WAIT: if (gap_cnt >= thr_q) begin
        st_d = TX_SEND;
        pc_d = '0;
      end
      TX_SEND: if (tick) begin
        if (pc_q == PC_LST) begin
          pc_d   = '0;
          sh_d   = {sh_q[SH_W-2:0], 1'b0};
          left_d = left_q - 1'b1;
          if (left_q == TOT_W'(1)) st_d = TX_IDLE;
        end else begin
          pc_d = pc_q + 1'b1;
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      pc_q   <= '0;
      thr_q  <= '0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      pc_q   <= pc_d;
      thr_q  <= thr_d;
    end
  end

  assign coil_load = (st_q == TX_SEND) &&
                     (sh_q[SH_W-1] ? (pc_q < PC_HLF) : (pc_q >= PC_HLF));
  assign busy      = (st_q != TX_IDLE);
endmodule

// File: rtl/lf_gap_responder.sv
module lf_gap_responder #(
  parameter int FRAME_BITS  = 80,
  parameter int CNT_W       = 9,
  parameter int SYNC_STAGES = 2,
  parameter int T_ZERO_MIN  = 15,
  parameter int T_ONE_MIN   = 24,
  parameter int T_EOF       = 40,
  parameter int START_BITS  = 5,
  parameter int BIT_PERIODS = 31,
  parameter int HALF_PER    = 15,
  parameter int GUARD       = 8,
  localparam int LEN_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  field_in,
  input  logic                  tick,
  input  logic                  rsp_req,
  input  logic [LEN_W-1:0]      rsp_len,
  input  logic [FRAME_BITS-1:0] rsp_bits,
  input  logic [CNT_W-1:0]      fdt,
  output logic                  coil_load,
  output logic                  busy,
  output logic                  frame_done,
  output logic [LEN_W-1:0]      frame_len,
  output logic [FRAME_BITS-1:0] frame_data
);
  logic             rise_raw, rise_ok;
  logic [CNT_W-1:0] gap_cnt;

  lfgr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(field_in), .rise(rise_raw)
  );

  // reader edges are not observed while a reply is pending or on air
  assign rise_ok = rise_raw & ~busy;

  lfgr_gap_rx #(
    .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W), .T_ZERO_MIN(T_ZERO_MIN),
    .T_ONE_MIN(T_ONE_MIN), .T_EOF(T_EOF)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rise(rise_ok),
    .gap_cnt(gap_cnt), .frame_done(frame_done),
    .frame_len(frame_len), .frame_data(frame_data)
  );

  lfgr_manch_tx #(
    .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W), .START_BITS(START_BITS),
    .BIT_PERIODS(BIT_PERIODS), .HALF_PER(HALF_PER), .GUARD(GUARD)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gap_cnt(gap_cnt),
    .rsp_req(rsp_req), .rsp_len(rsp_len), .rsp_bits(rsp_bits),
    .fdt(fdt), .coil_load(coil_load), .busy(busy)
  );
endmodule

// File: rtl/lf_gap_responder_chk.sv
module lf_gap_responder_chk #(
  parameter int FRAME_BITS = 80,
  localparam int LEN_W     = $clog2(FRAME_BITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsp_req,
  input logic             busy,
  input logic             coil_load,
  input logic             frame_done,
  input logic [LEN_W-1:0] frame_len
);
  p_idle_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !coil_load);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_len != '0 && frame_len <= LEN_W'(FRAME_BITS)));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_req && !busy) |=> busy);
endmodule

bind lf_gap_responder lf_gap_responder_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_req(rsp_req), .busy(busy),
  .coil_load(coil_load), .frame_done(frame_done), .frame_len(frame_len)
);

// File: tb/lf_gap_responder_tb_top.sv
module lf_gap_responder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TD  = 4;   // clocks per carrier period
  localparam int BP  = 31;  // periods per reply bit
  localparam int FB  = 80;

  typedef struct {
    int          n;
    logic [84:0] pat;   // first bit at [84]
    longint      st;
  } rsp_exp_t;

  typedef struct {
    int          len;
    logic [79:0] dat;
  } frm_exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        field_in;
  logic        tick;
  logic        rsp_req;
  logic [6:0]  rsp_len;
  logic [79:0] rsp_bits;
  logic [8:0]  fdt;
  logic        coil_load, busy, frame_done;
  logic [6:0]  frame_len;
  logic [79:0] frame_data;

  longint cyc = 0;
  longint last_rise = 0;
  int checks = 0, errors = 0;
  int frames_seen = 0, replies_seen = 0;
  bit done_all = 1'b0;

  frm_exp_t frm_q[$];
  rsp_exp_t rsp_q[$];

  lf_gap_responder dut_i (
    .clk(clk), .rst_n(rst_n), .field_in(field_in), .tick(tick),
    .rsp_req(rsp_req), .rsp_len(rsp_len), .rsp_bits(rsp_bits), .fdt(fdt),
    .coil_load(coil_load), .busy(busy), .frame_done(frame_done),
    .frame_len(frame_len), .frame_data(frame_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick <= (cyc % TD == 0);

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_to(input longint target);
    while (cyc < target) @(negedge clk);
  endtask

  // one reader gap: rising edge now, next rising edge n periods later
  task automatic gap(input int n);
    field_in = 1'b1;
    last_rise = cyc;
    repeat ((n - 4) * TD) @(negedge clk);
    field_in = 1'b0;
    repeat (4 * TD) @(negedge clk);
  endtask

  task automatic edge_only();
    field_in = 1'b1;
    last_rise = cyc;
    repeat (4 * TD) @(negedge clk);
    field_in = 1'b0;
  endtask

  task automatic idle(input int periods);
    repeat (periods * TD) @(negedge clk);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!frame_done);
  endtask

  task automatic request(input int len, input logic [79:0] bits, input int f, input longint exp_st);
    rsp_exp_t e;
    int nb;
    nb = (len > FB) ? FB : len;
    e.n   = 5 + nb;
    e.pat = {5'b11111, bits};
    e.st  = exp_st;
    rsp_q.push_back(e);
    rsp_len  = 7'(len);
    rsp_bits = bits;
    fdt      = 9'(f);
    rsp_req  = 1'b1;
    @(negedge clk);
    rsp_req  = 1'b0;
    chk(busy == 1'b1, "R10 busy after request", 96'(busy), 96'd1);
  endtask

  // frame monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && frame_done) begin
        frames_seen++;
        if (frm_q.size() == 0) begin
          chk(1'b0, "R3 unexpected frame_done", 96'(frame_len), 96'd0);
        end else begin
          frm_exp_t f;
          f = frm_q.pop_front();
          chk(frame_len == 7'(f.len), "R3 R5 frame_len", 96'(frame_len), 96'(f.len));
          chk(frame_data == f.dat, "R1 R2 R4 R5 frame_data", 96'(frame_data), 96'(f.dat));
        end
      end
    end
  end

  // reply monitor
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && coil_load && !prev && busy) begin
        longint c0;
        rsp_exp_t e;
        logic [84:0] got;
        bit shape_ok;
        c0 = cyc;
        replies_seen++;
        got = '0;
        shape_ok = 1'b1;
        if (rsp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected reply", 96'(c0), 96'd0);
          e.n = 5; e.pat = '0; e.st = c0;
        end else e = rsp_q.pop_front();
        chk((c0 - e.st) <= TD + 6 && (e.st - c0) <= TD + 6, "R6 reply start cycle",
            96'(c0), 96'(e.st));
        for (int k = 0; k < e.n; k++) begin
          logic a, b;
          wait_to(c0 + longint'(k * BP * TD + 7 * TD));
          a = coil_load;
          wait_to(c0 + longint'(k * BP * TD + 22 * TD));
          b = coil_load;
          if (a == b) shape_ok = 1'b0;
          got[84 - k] = a;
        end
        chk(shape_ok, "R8 halves differ in every bit", 96'(shape_ok), 96'd1);
        chk(got == (e.pat & ({85{1'b1}} << (85 - e.n))), "R7 R8 reply bits",
            96'(got >> 13), 96'(e.pat >> 13));
        wait_to(c0 + longint'(e.n * BP * TD + 2 * TD));
        chk(busy == 1'b0, "R10 busy released after last bit", 96'(busy), 96'd0);
        chk(coil_load == 1'b0, "R9 coil open after reply", 96'(coil_load), 96'd0);
        prev = 1'b0;
      end else prev = coil_load;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // driver
  initial begin
    frm_exp_t fa, fbx;
    logic [84:0] bpat;
    rst_n = 1'b0; field_in = 1'b0; rsp_req = 1'b0;
    rsp_len = '0; rsp_bits = '0; fdt = '0;
    repeat (5) @(negedge clk);
    chk(coil_load == 1'b0, "R9 reset coil_load", 96'(coil_load), 96'd0);
    chk(busy == 1'b0, "R10 reset busy", 96'(busy), 96'd0);
    chk(frame_done == 1'b0, "R3 reset frame_done", 96'(frame_done), 96'd0);
    rst_n = 1'b1;
    idle(60);   // empty frame timeout: no pulse expected (R3)

    // frame A: thresholds of R1 and R2, first gap after timeout dropped (R4)
    fa.len = 6;
    fa.dat = {6'b001110, 74'd0};
    frm_q.push_back(fa);
    gap(14); gap(15); gap(23); gap(24); gap(40); gap(30); gap(18);
    edge_only();
    wait_done();
    request(8, {8'hA5, 72'd0}, 208, last_rise + 200 * TD);
    // R11 and R10: reader edges and a second request during the reply
    idle(30);
    rsp_len = 7'd80; rsp_bits = '1; fdt = 9'd9;
    rsp_req = 1'b1; @(negedge clk); rsp_req = 1'b0;
    for (int i = 0; i < 6; i++) begin edge_only(); idle(16); end
    while (busy) @(negedge clk);
    idle(80);

    // frame B: 85 bits, only the first 80 kept (R5)
    bpat = '0;
    for (int i = 0; i < 85; i++) bpat[84 - i] = (i % 3 == 0);
    fbx.len = 80;
    fbx.dat = bpat[84:5];
    frm_q.push_back(fbx);
    for (int i = 0; i < 85; i++) gap((i % 3 == 0) ? 28 : 18);
    edge_only();
    wait_done();
    request(100, 80'hF0E1_D2C3_B4A5_9687_7869, 60, last_rise + 52 * TD);
    while (busy) @(negedge clk);
    idle(20);

    // empty payload, turnaround below guard: starts at once (R6, R7)
    request(0, 80'd0, 5, cyc);
    while (busy) @(negedge clk);
    idle(60);

    chk(frames_seen == 2, "R3 R11 frame count", 96'(frames_seen), 96'd2);
    chk(replies_seen == 3, "R10 reply count", 96'(replies_seen), 96'd3);
    chk(frm_q.size() == 0 && rsp_q.size() == 0, "R3 R7 scoreboard drained",
        96'(frm_q.size() + rsp_q.size()), 96'd0);
    done_all = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule